// File: doc/BRIEF.md
# Sign-range gated adder/subtractor

This block adds or subtracts two 16-bit two's-complement words while keeping the upper byte of its adder quiet whenever that byte carries no information of its own. Each operand is cut into a lower part (bits 7..0) and an upper part (bits 15..8). The lower part is always added. A detector looks at the upper bytes of operand A and of the effective operand B (B itself, or its bitwise inverse when subtracting). When both upper bytes are pure sign fill (all zeros or all ones), the detector marks the upper part as closed. In that case the upper adder sees only zeros, and its byte of the result is rebuilt from two flags: a sign flag and a carry-control flag. Both flags are derived from the lower-part carry.

The detector's outputs pass through 1-bit registers, captured on the same edge as the operand data. The combinational detector may glitch while its inputs settle, and that activity never reaches the datapath. Subtraction is carried out as A plus the inverse of B, with a carry-in of one into the lower part. The result is always (A + B) or (A - B) modulo 2^16.

Operands enter and results leave over valid/ready handshakes, with one register stage between them. An operand is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result is presented on `out_valid` from the next cycle on. A result is held, unchanged, until a clock edge where `out_ready` is high. The input side accepts when the stage is empty or when its held result is leaving on the same edge. `upper_off` travels with the result and shows whether the upper adder was closed for it.

Top module: `sxg_addsub`

## Requirements
- R1: With `in_sub` = 0, the delivered result equals (A + B) mod 2^16 for every operand pair.
- R2: With `in_sub` = 1, the delivered result equals (A - B) mod 2^16, and detection uses the bitwise inverse of B's upper byte.
- R3: `upper_off` delivered with a result is 1 exactly when A[15:8] is 0x00 or 0xFF and the effective B[15:8] is 0x00 or 0xFF; otherwise it is 0.
- R4: All six closed cases give the exact result. These are the three upper-byte pairings (both 0x00, mixed, both 0xFF), each with and without a carry out of bit 7. Whenever `upper_off` is 1, result bits 15..9 are all equal.
- R5: A result appears with `out_valid` = 1 in the cycle after its operands are accepted.
- R6: While `out_valid` = 1 and `out_ready` = 0, `out_data` and `upper_off` stay stable and `out_valid` stays high. `in_ready` equals (not `out_valid`) or `out_ready`.
- R7: During reset, `out_valid` = 0, `in_ready` = 1 and `upper_off` = 0.
- R8: Results leave in the order their operands were accepted, with none lost or repeated under arbitrary stalls on either side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand word present |
| in_ready | output | 1 | Stage can take an operand this cycle |
| in_a | input | 16 | Operand A, two's complement |
| in_b | input | 16 | Operand B, two's complement |
| in_sub | input | 1 | 1 selects A - B, 0 selects A + B |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 16 | Result word |
| upper_off | output | 1 | Upper adder was closed for this result |

## Verification
The checker watches every cycle. It compares each presented result with the arithmetic value of the operands accepted for it, and it compares the closed flag with the sign-fill condition of those operands. It also checks that a closed result has a uniform top seven bits, that data holds while a result is stalled, and that the input-ready rule is followed. Some behaviour can only be shown by the bench's scenarios. The directed operands reach each of the six closed cases in both modes, and random back-pressure checks ordering with nothing lost or repeated. The bench also matches the count of closed transfers against the count expected from the operands, and checks the reset state.

// File: rtl/sxg_pkg.sv
package sxg_pkg;
  // Registered control word produced by the sign-range detector.
  typedef struct packed {
    logic off;   // upper part closed
    logic sgn;   // rebuilt sign fill
    logic kctl;  // rebuilt bit 0 correction
  } sxg_flags_t;
endpackage

// File: rtl/sxg_part_add.sv
module sxg_part_add #(
  parameter int PW = 8
) (
  input  logic [PW-1:0] opa,
  input  logic [PW-1:0] opb,
  input  logic          cin,
  output logic [PW-1:0] sum,
  output logic          cout
);
  logic [PW:0] wide;
  assign wide = {1'b0, opa} + {1'b0, opb} + {{PW{1'b0}}, cin};
  assign sum  = wide[PW-1:0];
  assign cout = wide[PW];
endmodule

// File: rtl/sxg_detect.sv
module sxg_detect
  import sxg_pkg::*;
#(
  parameter int MW = 8
) (
  input  logic [MW-1:0] a_hi,
  input  logic [MW-1:0] b_hi,
  input  logic          lsp_cy,
  output sxg_flags_t    flags
);
  logic [MW-1:0] hi [2];
  logic [1:0]    all1;
  logic [1:0]    all0;

  assign hi[0] = a_hi;
  assign hi[1] = b_hi;

  for (genvar k = 0; k < 2; k++) begin : g_op
    assign all1[k] = &hi[k];
    assign all0[k] = ~|hi[k];
  end

  logic ext_a, ext_b, both1, both0, mixed;
  assign ext_a = all1[0] | all0[0];
  assign ext_b = all1[1] | all0[1];
  assign both1 = all1[0] & all1[1];
  assign both0 = all0[0] & all0[1];
  assign mixed = (all1[0] & all0[1]) | (all0[0] & all1[1]);

  // Upper byte value of the sum is {sgn x7, sgn^kctl} in every closed case.
  assign flags.off  = ext_a & ext_b;
  assign flags.sgn  = both1 | (mixed & ~lsp_cy);
  assign flags.kctl = (both0 & lsp_cy) | (both1 & ~lsp_cy);
endmodule

// File: rtl/sxg_signext.sv
module sxg_signext
  import sxg_pkg::*;
#(
  parameter int MW = 8
) (
  input  sxg_flags_t    flags,
  input  logic [MW-1:0] msp_sum,
  output logic [MW-1:0] msp_out
);
  logic [MW-1:0] rebuilt;
  assign rebuilt = {{(MW-1){flags.sgn}}, flags.sgn ^ flags.kctl};
  assign msp_out = flags.off ? rebuilt : msp_sum;
endmodule

// File: rtl/sxg_addsub.sv
module sxg_addsub
  import sxg_pkg::*;
#(
  parameter int W  = 16,
  parameter int LW = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_b,
  input  logic         in_sub,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         upper_off
);
  localparam int MW = W - LW;

  // ---- input side: effective B, lower add, detection, gating ----
  logic [W-1:0]  b_eff;
  logic [LW-1:0] lsp_sum;
  logic          lsp_cy;
  sxg_flags_t    det;
  logic [MW-1:0] a_hi_g, b_hi_g;
  logic          accept;

  assign b_eff = in_sub ? ~in_b : in_b;

  sxg_part_add #(.PW(LW)) u_lsp (
    .opa (in_a[LW-1:0]),
    .opb (b_eff[LW-1:0]),
    .cin (in_sub),
    .sum (lsp_sum),
    .cout(lsp_cy)
  );

  sxg_detect #(.MW(MW)) u_det (
    .a_hi  (in_a[W-1:LW]),
    .b_hi  (b_eff[W-1:LW]),
    .lsp_cy(lsp_cy),
    .flags (det)
  );

  // AND gating: upper operands forced to zero when the upper part is closed
  assign a_hi_g = in_a[W-1:LW]  & {MW{~det.off}};
  assign b_hi_g = b_eff[W-1:LW] & {MW{~det.off}};

  // ---- stage registers ----
  logic          vld_q;
  logic [LW-1:0] lsp_q;
  logic          cy_q;
  logic [MW-1:0] a_hi_q, b_hi_q;
  sxg_flags_t    flg_q;

  assign in_ready = ~vld_q | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      lsp_q  <= '0;
      cy_q   <= 1'b0;
      a_hi_q <= '0;
      b_hi_q <= '0;
      flg_q  <= '0;
    end else if (accept) begin
      vld_q  <= 1'b1;
      lsp_q  <= lsp_sum;
      cy_q   <= lsp_cy;
      a_hi_q <= a_hi_g;
      b_hi_q <= b_hi_g;
      flg_q  <= det;
    end else if (out_ready) begin
      vld_q  <= 1'b0;
    end
  end

  // ---- output side: upper add and sign-extension rebuild ----
  logic [MW-1:0] msp_sum, msp_res;
  logic          msp_cy_unused_n;

  sxg_part_add #(.PW(MW)) u_msp (
    .opa (a_hi_q),
    .opb (b_hi_q),
    .cin (cy_q),
    .sum (msp_sum),
    .cout(msp_cy_unused_n)
  );

  sxg_signext #(.MW(MW)) u_sx (
    .flags  (flg_q),
    .msp_sum(msp_sum),
    .msp_out(msp_res)
  );

  assign out_valid = vld_q;
  assign out_data  = {msp_res, lsp_q};
  assign upper_off = flg_q.off;

  // carry out of bit W-1 is dropped: results are modulo 2^W
  logic drop_sink;
  assign drop_sink = msp_cy_unused_n & 1'b0;
  logic unused_ok;
  assign unused_ok = drop_sink;
endmodule

// File: rtl/sxg_addsub_chk.sv
module sxg_addsub_chk #(
  parameter int W  = 16,
  parameter int LW = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_a,
  input logic [W-1:0] in_b,
  input logic         in_sub,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic         upper_off
);
  localparam int MW = W - LW;

  logic [W-1:0] ref_q;
  logic         ref_off_q;
  logic [MW-1:0] bh;
  logic         ext_now;

  assign bh = in_sub ? ~in_b[W-1:LW] : in_b[W-1:LW];
  assign ext_now = ((in_a[W-1:LW] == '0) || (in_a[W-1:LW] == '1)) &&
                   ((bh == '0) || (bh == '1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q     <= '0;
      ref_off_q <= 1'b0;
    end else if (in_valid && in_ready) begin
      ref_q     <= in_sub ? (in_a - in_b) : (in_a + in_b);
      ref_off_q <= ext_now;
    end
  end

  // R1 R2
  sum_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data == ref_q);

  // R3
  off_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> upper_off == ref_off_q);

  // R4
  fill_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && upper_off) |->
      ($countones(out_data[W-1:LW+1]) == 0 || $countones(out_data[W-1:LW+1]) == MW-1));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(upper_off)));

  // R6
  ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready == (!out_valid || out_ready));
endmodule

bind sxg_addsub sxg_addsub_chk #(.W(W), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_a(in_a), .in_b(in_b), .in_sub(in_sub), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .upper_off(upper_off)
);

// File: tb/sxg_addsub_test.sv
module sxg_addsub_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_a = '0;
  logic [15:0] in_b = '0;
  logic        in_sub = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;
  logic        upper_off;

  int checks = 0;
  int fails  = 0;
  int exp_closed = 0;
  int got_closed = 0;
  int bp_mode = 0;   // 0 always ready, 1 random stalls
  logic [16:0] sb [$];

  always #10 clk = ~clk;  // 50 MHz

  sxg_addsub uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_sub(in_sub), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .upper_off(upper_off)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  // driver: pushes expected item when the handshake is certain
  task automatic send(input logic [15:0] a, input logic [15:0] b, input logic s);
    logic [7:0] bh;
    logic off_e;
    logic [15:0] res_e;
    @(negedge clk);
    in_valid = 1'b1; in_a = a; in_b = b; in_sub = s;
    #1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    bh = s ? ~b[15:8] : b[15:8];
    off_e = (a[15:8] == 8'h00 || a[15:8] == 8'hFF) && (bh == 8'h00 || bh == 8'hFF);
    res_e = s ? a - b : a + b;
    if (off_e) exp_closed++;
    sb.push_back({off_e, res_e});
    @(posedge clk);
  endtask

  // back-pressure driver
  initial begin
    forever begin
      @(negedge clk);
      out_ready = (bp_mode == 0) ? 1'b1 : 1'($urandom % 3 != 0);
    end
  end

  // monitor
  initial begin
    logic        stalled = 1'b0;
    logic [16:0] held = '0;
    logic [16:0] item;
    forever begin
      @(negedge clk); #2;
      if (rst_n) begin
        check("R6 in_ready rule", 32'(in_ready), 32'(!out_valid || out_ready));
        if (stalled) begin
          check("R6 stall valid", 32'(out_valid), 32'd1);
          check("R6 stall hold", {15'd0, upper_off, out_data}, {15'd0, held});
        end
        stalled = out_valid && !out_ready;
        held = {upper_off, out_data};
        if (out_valid && out_ready) begin
          if (sb.size() == 0) begin
            check("R8 unexpected result", {15'd0, upper_off, out_data}, 32'hFFFF_FFFF);
          end else begin
            item = sb.pop_front();
            check("R1 R2 R8 result", 32'(out_data), 32'(item[15:0]));
            check("R3 upper_off", 32'(upper_off), 32'(item[16]));
            if (upper_off) begin
              got_closed++;
              check("R4 fill shape", 32'(out_data[15:9] == 7'h00 || out_data[15:9] == 7'h7F), 32'd1);
            end
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R7 reset state
    #25;
    check("R7 out_valid in reset", 32'(out_valid), 32'd0);
    check("R7 in_ready in reset", 32'(in_ready), 32'd1);
    check("R7 upper_off in reset", 32'(upper_off), 32'd0);
    @(negedge clk); rst_n = 1'b1;

    // R5 latency: accept at an edge, result visible right after it
    @(negedge clk);
    in_valid = 1'b1; in_a = 16'h0102; in_b = 16'h0304; in_sub = 1'b0;
    out_ready = 1'b0;
    sb.push_back({1'b0, 16'h0406});
    @(posedge clk); #1;
    in_valid = 1'b0;
    check("R5 valid after one cycle", 32'(out_valid), 32'd1);
    check("R5 data after one cycle", 32'(out_data), 32'h0406);
    repeat (3) @(posedge clk);

    // R4 six closed cases, add and subtract (R1, R2)
    for (int m = 0; m < 2; m++) begin
      send(16'h0010, 16'h0020, 1'(m));
      send(16'h00F0, 16'h0020, 1'(m));
      send(16'h0010, 16'hFF20, 1'(m));
      send(16'h00F0, 16'hFF20, 1'(m));
      send(16'hFF10, 16'hFF20, 1'(m));
      send(16'hFFF0, 16'hFF20, 1'(m));
      send(16'h1234, 16'h0101, 1'(m));
      send(16'h8000, 16'h7FFF, 1'(m));
      send(16'hFFFF, 16'h0001, 1'(m));
      send(16'h0000, 16'h0000, 1'(m));
    end
    // subtract cases landing in each closed class via inverted B
    send(16'h0030, 16'h0010, 1'b1);
    send(16'h0010, 16'h0030, 1'b1);
    send(16'hFF10, 16'h0020, 1'b1);
    send(16'hFFF0, 16'hFF10, 1'b1);
    send(16'h0005, 16'hFF05, 1'b1);

    // random traffic under back-pressure (R6, R8)
    bp_mode = 1;
    for (int i = 0; i < 600; i++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom);
      rb = 16'($urandom);
      if (i % 4 == 0) ra = {{8{ra[7]}}, ra[7:0]};
      if (i % 4 == 0) rb = {{8{rb[7]}}, rb[7:0]};
      send(ra, rb, 1'($urandom));
      if (i % 7 == 0) begin
        @(negedge clk); in_valid = 1'b0;
      end
    end
    @(negedge clk); in_valid = 1'b0;
    bp_mode = 0;
    repeat (10) @(posedge clk);
    check("R8 scoreboard drained", 32'(sb.size()), 32'd0);
    check("R3 closed transfer count", 32'(got_closed), 32'(exp_closed));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule